// File: doc/BRIEF.md
# Burst Legality Gate

This block sits in front of an external memory controller and judges every bus request before any transfer starts. A request names a direction (read or write), a length in 32-bit words, the word offset of its first beat inside the aligned 32-byte line (byte address bits [4:2]), the kind of memory it targets and a four-bit byte-enable mask. The gate compares the request against the allowed combinations of length and start offset, the rule that no burst may leave its aligned 32-byte line, the rules for byte masks, and the rules for flash writes. It returns a registered verdict: an accept flag and a three-bit reason code.

Requests and verdicts both use a valid/ready handshake. A request is taken on a rising clock edge when `req_valid` and `req_ready` are both high. Its verdict appears on `rsp_*` on the next cycle and stays there, unchanged, until the consumer raises `rsp_ready`. The single verdict register gives back-pressure directly: `req_ready` is high when the register is empty or is being drained in the same cycle. A new request can therefore be taken every cycle while `rsp_ready` stays high. `cfg_flash_wide` is a plain static control pin that gives the width of the flash data bus.

Top module: `burst_legality_gate`

## Requirements
- R1: A request taken at a clock edge gives `rsp_valid` high with its verdict after that edge. After reset `rsp_valid` is low, and with no new request it falls after the verdict has been taken with `rsp_ready`.
- R2: `req_ready` equals (not `rsp_valid`) or `rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, the verdict stays stable and no request is taken.
- R3: Supported lengths are 1, 4 and 8 words for reads and 1, 2, 3, 4 and 8 words for writes. Any other `req_len` value, 0 included, gives reason 1.
- R4: A one-word read or write is allowed at every offset 0 to 7. A read is judged without regard to its byte mask.
- R5: A supported burst that stays inside its line but starts at a forbidden offset gives reason 2. Allowed offsets are 0 or 4 for 4-word reads and 4-word writes, 0 for 8-word transfers, {0,1,2,4,5,6} for 2-word writes and {0,1,4,5} for 3-word writes.
- R6: A supported request with offset + length > 8 would leave the aligned 32-byte line and gives reason 3.
- R7: A write burst (length above 1) must have `req_byte_en` = 4'b1111. A one-word write must enable at least one byte. A violation gives reason 4.
- R8: A write to flash (`req_mem_type` = 2'd3) must be one word. Its mask must be 4'b1111 when `cfg_flash_wide` = 1, or exactly 4'b0011 or 4'b1100 when it is 0. A violation gives reason 5. Flash reads follow the general rules. The other type codes are 0 SDRAM, 1 SRAM and 2 variable-latency I/O.
- R9: When several rules fail, the lowest non-zero reason is reported. `rsp_accept` is high exactly when the reason is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Gate can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | 4 | Burst length in words |
| req_word_offset | input | 3 | Word offset of first beat in the 32-byte line |
| req_mem_type | input | 2 | Target memory kind (3 = flash) |
| req_byte_en | input | 4 | Byte enables, bit n covers byte lane n |
| cfg_flash_wide | input | 1 | 1 = 32-bit flash bus, 0 = 16-bit |
| rsp_valid | output | 1 | Verdict present |
| rsp_ready | input | 1 | Consumer takes the verdict |
| rsp_accept | output | 1 | Request is legal |
| rsp_reason | output | 3 | 0 legal, 1 length, 2 offset, 3 line crossing, 4 mask, 5 flash |

## Verification
The only state is one verdict register with its valid bit, so any internal fault shows at the ports within one cycle of the request that exposes it. A wrong permission entry or priority order puts a wrong reason code on `rsp_reason` in the cycle after the request is taken. A valid bit that is stuck or not cleared shows as `rsp_valid` staying high after a drain, or as `req_ready` staying low. A register that is reloaded during a stall shows as a changed verdict while `rsp_ready` is low.

// File: rtl/blg_pkg.sv
package blg_pkg;

  // Verdict codes; numeric order is also the reporting priority.
  typedef enum logic [2:0] {
    RSN_OK     = 3'd0,
    RSN_LEN    = 3'd1,
    RSN_OFFSET = 3'd2,
    RSN_CROSS  = 3'd3,
    RSN_MASK   = 3'd4,
    RSN_FLASH  = 3'd5
  } reason_e;

  // Target memory kinds as encoded on the request.
  typedef enum logic [1:0] {
    MEM_SDRAM  = 2'd0,
    MEM_SRAM   = 2'd1,
    MEM_IO_VAR = 2'd2,
    MEM_FLASH  = 2'd3
  } mem_kind_e;

endpackage

// File: rtl/blg_shape_check.sv
// Judges length, start offset and line containment of one request.
module blg_shape_check #(
  parameter int LINE_WORDS = 8,
  localparam int OFF_W = $clog2(LINE_WORDS),
  localparam int LEN_W = OFF_W + 1
) (
  input  logic             is_write,
  input  logic [LEN_W-1:0] len,
  input  logic [OFF_W-1:0] offset,
  output logic             len_bad,
  output logic             off_bad,
  output logic             crosses
);

  localparam int HALF_WORDS = LINE_WORDS / 2;

  // Permission of one start slot for the current length and direction.
  function automatic logic slot_ok(input int slot, input int words, input logic wr);
    logic ok;
    ok = 1'b0;
    if (words == 1)
      ok = 1'b1;
    else if (words == LINE_WORDS)
      ok = (slot == 0);
    else if (wr && words >= 2 && words <= HALF_WORDS)
      ok = ((slot % HALF_WORDS) + words) <= HALF_WORDS;
    else if (!wr && words == HALF_WORDS)
      ok = (slot % HALF_WORDS) == 0;
    return ok;
  endfunction

  int words_i;
  int start_i;
  logic [LINE_WORDS-1:0] slot_perm;

  assign words_i = int'(len);
  assign start_i = int'(offset);

  // One permission bit per start slot in the line.
  for (genvar s = 0; s < LINE_WORDS; s++) begin : g_slot
    assign slot_perm[s] = slot_ok(s, words_i, is_write);
  end

  always_comb begin
    len_bad = 1'b1;
    if (words_i == 1 || words_i == HALF_WORDS || words_i == LINE_WORDS)
      len_bad = 1'b0;
    else if (is_write && words_i >= 2 && words_i <= HALF_WORDS)
      len_bad = 1'b0;
  end

  assign crosses = (start_i + words_i) > LINE_WORDS;
  assign off_bad = !crosses && !slot_perm[offset];

endmodule

// File: rtl/blg_mask_check.sv
// Judges byte-enable use and the flash write rules.
module blg_mask_check #(
  parameter int BE_W  = 4,
  parameter int LEN_W = 4
) (
  input  logic             is_write,
  input  logic             is_flash,
  input  logic             flash_wide,
  input  logic [LEN_W-1:0] len,
  input  logic [BE_W-1:0]  byte_en,
  output logic             mask_bad,
  output logic             flash_bad
);

  localparam int HALF_BE = BE_W / 2;
  localparam logic [BE_W-1:0] ALL_ON  = {BE_W{1'b1}};
  localparam logic [BE_W-1:0] LOW_ON  = {{(BE_W-HALF_BE){1'b0}}, {HALF_BE{1'b1}}};
  localparam logic [BE_W-1:0] HIGH_ON = {{(BE_W-HALF_BE){1'b1}}, {HALF_BE{1'b0}}};

  logic single;
  logic width_match;

  assign single = (int'(len) == 1);

  always_comb begin
    if (flash_wide)
      width_match = (byte_en == ALL_ON);
    else
      width_match = (byte_en == LOW_ON) || (byte_en == HIGH_ON);
  end

  always_comb begin
    mask_bad = 1'b0;
    if (is_write) begin
      if (single)
        mask_bad = (byte_en == '0);
      else
        mask_bad = (byte_en != ALL_ON);
    end
  end

  assign flash_bad = is_write && is_flash && (!single || !width_match);

endmodule

// File: rtl/blg_verdict_stage.sv
// Priority encoder plus the single registered verdict slot.
module blg_verdict_stage
  import blg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_valid,
  output logic    in_ready,
  input  logic    len_bad,
  input  logic    off_bad,
  input  logic    crosses,
  input  logic    mask_bad,
  input  logic    flash_bad,
  output logic    out_valid,
  input  logic    out_ready,
  output logic    out_accept,
  output reason_e out_reason
);

  reason_e reason_d;
  logic    vld_q;
  logic    acc_q;
  reason_e reason_q;
  logic    take;

  always_comb begin
    if (len_bad)        reason_d = RSN_LEN;
    else if (off_bad)   reason_d = RSN_OFFSET;
    else if (crosses)   reason_d = RSN_CROSS;
    else if (mask_bad)  reason_d = RSN_MASK;
    else if (flash_bad) reason_d = RSN_FLASH;
    else                reason_d = RSN_OK;
  end

  assign in_ready = !vld_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q    <= 1'b0;
      acc_q    <= 1'b0;
      reason_q <= RSN_OK;
    end else if (take) begin
      vld_q    <= 1'b1;
      acc_q    <= (reason_d == RSN_OK);
      reason_q <= reason_d;
    end else if (out_ready) begin
      vld_q    <= 1'b0;
    end
  end

  assign out_valid  = vld_q;
  assign out_accept = acc_q;
  assign out_reason = reason_q;

  // R1
  taken_gives_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R2
  stall_holds_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_reason) && $stable(out_accept)));

  // R2
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R1
  drain_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

endmodule

// File: rtl/burst_legality_gate.sv
module burst_legality_gate
  import blg_pkg::*;
#(
  parameter int LINE_WORDS = 8,
  parameter int BE_W       = 4,
  localparam int OFF_W = $clog2(LINE_WORDS),
  localparam int LEN_W = OFF_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [LEN_W-1:0] req_len,
  input  logic [OFF_W-1:0] req_word_offset,
  input  logic [1:0]       req_mem_type,
  input  logic [BE_W-1:0]  req_byte_en,
  input  logic             cfg_flash_wide,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_accept,
  output logic [2:0]       rsp_reason
);

  logic    len_bad, off_bad, crosses, mask_bad, flash_bad;
  logic    is_flash;
  reason_e reason_w;

  assign is_flash = (mem_kind_e'(req_mem_type) == MEM_FLASH);

  blg_shape_check #(.LINE_WORDS(LINE_WORDS)) u_shape (
    .is_write (req_write),
    .len      (req_len),
    .offset   (req_word_offset),
    .len_bad  (len_bad),
    .off_bad  (off_bad),
    .crosses  (crosses)
  );

  blg_mask_check #(.BE_W(BE_W), .LEN_W(LEN_W)) u_mask (
    .is_write   (req_write),
    .is_flash   (is_flash),
    .flash_wide (cfg_flash_wide),
    .len        (req_len),
    .byte_en    (req_byte_en),
    .mask_bad   (mask_bad),
    .flash_bad  (flash_bad)
  );

  blg_verdict_stage u_verdict (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (req_valid),
    .in_ready   (req_ready),
    .len_bad    (len_bad),
    .off_bad    (off_bad),
    .crosses    (crosses),
    .mask_bad   (mask_bad),
    .flash_bad  (flash_bad),
    .out_valid  (rsp_valid),
    .out_ready  (rsp_ready),
    .out_accept (rsp_accept),
    .out_reason (reason_w)
  );

  assign rsp_reason = reason_w;

  // R4
  single_read_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && int'(req_len) == 1) |=> (rsp_accept && rsp_reason == 3'd0));

  // R6
  full_line_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && int'(req_len) == LINE_WORDS && req_word_offset != '0)
      |=> (!rsp_accept && rsp_reason == 3'd3));

  // R8
  flash_burst_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && is_flash && int'(req_len) > 1) |=> !rsp_accept);

  // R9
  accept_matches_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_accept == (rsp_reason == 3'd0)));

endmodule

// File: tb/sim_burst_legality_gate.sv
module sim_burst_legality_gate;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_ready, req_write;
  logic [3:0] req_len;
  logic [2:0] req_word_offset;
  logic [1:0] req_mem_type;
  logic [3:0] req_byte_en;
  logic       cfg_flash_wide;
  logic       rsp_valid, rsp_ready, rsp_accept;
  logic [2:0] rsp_reason;

  always #5 clk = ~clk;

  burst_legality_gate u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_len(req_len), .req_word_offset(req_word_offset),
    .req_mem_type(req_mem_type), .req_byte_en(req_byte_en),
    .cfg_flash_wide(cfg_flash_wide),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_accept(rsp_accept), .rsp_reason(rsp_reason)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // {req tag, write, len, offset, mem, byte_en, flash_wide, expected reason}
  localparam int NV = 31;
  localparam logic [21:0] VEC [NV] = '{
    {4'd4, 1'b0, 4'd1, 3'd7, 2'd0, 4'h0, 1'b1, 3'd0},  // R4 read mask ignored
    {4'd5, 1'b0, 4'd4, 3'd4, 2'd1, 4'hF, 1'b1, 3'd0},  // R5
    {4'd5, 1'b0, 4'd4, 3'd2, 2'd1, 4'hF, 1'b1, 3'd2},  // R5
    {4'd6, 1'b0, 4'd4, 3'd5, 2'd0, 4'hF, 1'b1, 3'd3},  // R6
    {4'd5, 1'b0, 4'd8, 3'd0, 2'd0, 4'hF, 1'b1, 3'd0},  // R5
    {4'd6, 1'b0, 4'd8, 3'd3, 2'd0, 4'hF, 1'b1, 3'd3},  // R6
    {4'd3, 1'b0, 4'd2, 3'd0, 2'd0, 4'hF, 1'b1, 3'd1},  // R3 read of 2
    {4'd5, 1'b1, 4'd2, 3'd6, 2'd0, 4'hF, 1'b1, 3'd0},  // R5
    {4'd5, 1'b1, 4'd2, 3'd3, 2'd0, 4'hF, 1'b1, 3'd2},  // R5
    {4'd6, 1'b1, 4'd2, 3'd7, 2'd0, 4'hF, 1'b1, 3'd3},  // R6
    {4'd5, 1'b1, 4'd3, 3'd5, 2'd1, 4'hF, 1'b1, 3'd0},  // R5
    {4'd5, 1'b1, 4'd3, 3'd2, 2'd1, 4'hF, 1'b1, 3'd2},  // R5
    {4'd5, 1'b1, 4'd4, 3'd4, 2'd2, 4'hF, 1'b1, 3'd0},  // R5
    {4'd5, 1'b1, 4'd8, 3'd0, 2'd0, 4'hF, 1'b1, 3'd0},  // R5
    {4'd3, 1'b1, 4'd5, 3'd0, 2'd0, 4'hF, 1'b1, 3'd1},  // R3
    {4'd3, 1'b1, 4'd0, 3'd0, 2'd0, 4'hF, 1'b1, 3'd1},  // R3 zero length
    {4'd4, 1'b1, 4'd1, 3'd3, 2'd0, 4'h4, 1'b1, 3'd0},  // R4 single byte write
    {4'd7, 1'b1, 4'd1, 3'd0, 2'd0, 4'h0, 1'b1, 3'd4},  // R7 empty mask
    {4'd7, 1'b1, 4'd2, 3'd0, 2'd0, 4'h7, 1'b1, 3'd4},  // R7 partial burst
    {4'd8, 1'b1, 4'd1, 3'd2, 2'd3, 4'hF, 1'b1, 3'd0},  // R8 wide flash
    {4'd8, 1'b1, 4'd1, 3'd2, 2'd3, 4'h3, 1'b0, 3'd0},  // R8 narrow low
    {4'd8, 1'b1, 4'd1, 3'd2, 2'd3, 4'hC, 1'b0, 3'd0},  // R8 narrow high
    {4'd8, 1'b1, 4'd1, 3'd0, 2'd3, 4'h3, 1'b1, 3'd5},  // R8
    {4'd8, 1'b1, 4'd1, 3'd0, 2'd3, 4'hF, 1'b0, 3'd5},  // R8
    {4'd8, 1'b1, 4'd4, 3'd0, 2'd3, 4'hF, 1'b1, 3'd5},  // R8 flash burst
    {4'd8, 1'b0, 4'd8, 3'd0, 2'd3, 4'h0, 1'b1, 3'd0},  // R8 flash read
    {4'd9, 1'b1, 4'd2, 3'd3, 2'd3, 4'h1, 1'b1, 3'd2},  // R9 offset first
    {4'd9, 1'b1, 4'd6, 3'd7, 2'd3, 4'h0, 1'b1, 3'd1},  // R9 length first
    {4'd9, 1'b1, 4'd3, 3'd6, 2'd0, 4'h1, 1'b1, 3'd3},  // R9 crossing before mask
    {4'd4, 1'b0, 4'd1, 3'd0, 2'd2, 4'h0, 1'b1, 3'd0},  // R4
    {4'd8, 1'b1, 4'd1, 3'd1, 2'd3, 4'h4, 1'b0, 3'd5}   // R8 one narrow byte
  };

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic drive(input logic [21:0] v);
    req_write       = v[17];
    req_len         = v[16:13];
    req_word_offset = v[12:10];
    req_mem_type    = v[9:8];
    req_byte_en     = v[7:4];
    cfg_flash_wide  = v[3];
    req_valid       = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_len = 4'd1;
    req_word_offset = 3'd0; req_mem_type = 2'd0; req_byte_en = 4'hF;
    cfg_flash_wide = 1'b1; rsp_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset valid", int'(rsp_valid), 0);
    chk("R2 reset ready", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      chk($sformatf("R1 vec %0d valid", i), int'(rsp_valid), 1);
      chk($sformatf("R%0d vec %0d reason", VEC[i][21:18], i), int'(rsp_reason), int'(VEC[i][2:0]));
      chk($sformatf("R9 vec %0d accept", i), int'(rsp_accept), int'(VEC[i][2:0] == 3'd0));
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk("R1 drained", int'(rsp_valid), 0);

    // R2 back-pressure: legal request, then stall with an illegal one waiting
    rsp_ready = 1'b0;
    drive({4'd2, 1'b1, 4'd4, 3'd0, 2'd0, 4'hF, 1'b1, 3'd0});
    @(negedge clk);
    chk("R2 stall valid", int'(rsp_valid), 1);
    chk("R2 stall ready low", int'(req_ready), 0);
    drive({4'd2, 1'b1, 4'd7, 3'd0, 2'd0, 4'hF, 1'b1, 3'd1});
    repeat (2) @(negedge clk);
    chk("R2 held reason", int'(rsp_reason), 0);
    chk("R2 held accept", int'(rsp_accept), 1);
    rsp_ready = 1'b1;
    #1;
    chk("R2 ready follows", int'(req_ready), 1);
    @(negedge clk);
    chk("R2 next reason", int'(rsp_reason), 1);
    chk("R2 next accept", int'(rsp_accept), 0);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R1 idle", int'(rsp_valid), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule